// File: doc/BRIEF.md
# Command Mailbox with Background Completion

This block is the device-side end of a register-mapped command mailbox. Host software loads an opcode and a payload length into the command word, then sets the doorbell bit in the control word. The block hands the command to a back-end executor. When the back end finishes, the block posts an immediate return code and clears the doorbell. A long command can instead be accepted as a background operation. In that case the immediate code says "background started" and the block then tracks the command in a separate background status word.

While a background operation runs, the back end streams percent-complete updates. The block clamps each update and exposes it. When the value reaches 100, the block latches a deferred return code and a vendor code. Software learns of completion in one of two ways. It can poll the percent field. Or it can set an enable bit and take a one-cycle interrupt pulse. Only one background operation runs at a time. A doorbell rung during one is refused with a busy code.

The register port is 64 bits wide and addressed by byte. Byte-address bits 4:3 pick a word: word 0 holds the capability in bits 31:0 and the control register at offset 0x04 in bits 63:32, word 1 (0x08) is the command, word 2 (0x10) is the status and word 3 (0x18) is the background status. Reads are combinational from the address.

Top module: `mbox_bg_ctrl`

## Requirements
- R1: After reset, control, command, status and background status all read zero, and the capability word reads its parameter value: exponent in bits 4:0, interrupt support in bit 6, message number in bits 10:7 (0x2CB by default).
- R2: Writes to the capability half of word 0, to the status word and to the background status word change nothing.
- R3: The command word holds the opcode in bits 15:0 and the length in bits 36:16; a write to it while the doorbell (control bit 0, word 0 bit 32) is set is ignored.
- R4: Writing 1 to the doorbell sets it; when no background operation runs, be_start_o pulses for exactly one cycle carrying the command's opcode and length; the doorbell then reads 1 until be_done_i and clears in the same cycle as the immediate return code becomes valid. Writing 0 to the doorbell does not clear it.
- R5: With be_bg_i low at be_done_i, status bits 47:32 take be_rc_i and status bit 0 stays 0.
- R6: With be_bg_i high at be_done_i, status bits 47:32 read 0x0001 and status bit 0 reads 1. The background word then shows the command's opcode in bits 15:0, with percent (bits 22:16), final code (bits 47:32) and vendor code (bits 63:48) all zero.
- R7: be_pct_valid_i during a background operation loads be_pct_i into the percent field, clamped to 100; while no background operation runs, it has no effect.
- R8: When the percent field reaches 100, status bit 0 clears and be_final_rc_i and be_vendor_i are latched into bits 47:32 and 63:48. Before that, those fields stay zero.
- R9: A doorbell while status bit 0 is set gives return code 0x0002, clears the doorbell, raises no be_start_o and leaves the background word unchanged.
- R10: irq_o pulses for one cycle, in the cycle after the percent field reaches 100, only if control bit 2 (word 0 bit 34) is set at that moment.
- R11: Control bit 2 reads back as written, so software can update it with a read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Byte address; bits 4:3 select the word |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for reg_addr_i |
| be_start_o | output | 1 | One-cycle command issue to the back end |
| be_opcode_o | output | 16 | Opcode of the issued command |
| be_len_o | output | 21 | Payload length of the issued command |
| be_done_i | input | 1 | Back end accepted or finished the command |
| be_bg_i | input | 1 | With be_done_i: command continues in background |
| be_rc_i | input | 16 | With be_done_i: immediate return code |
| be_pct_valid_i | input | 1 | Progress update strobe |
| be_pct_i | input | 8 | Percent complete, unclamped |
| be_final_rc_i | input | 16 | Final return code, sampled at 100 percent |
| be_vendor_i | input | 16 | Vendor code, sampled at 100 percent |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The hardest state to reach is a second doorbell that arrives while a background operation is still running. The same run must also have interrupts enabled at launch and disabled again before completion. The bench gets there by launching a background command and holding back its progress updates. With the operation still in flight, it rings the doorbell again and confirms that the busy code appears with no back-end issue. It then clears the enable bit and only after that drives the final percent, checking that no pulse appears. Out-of-range percent values (200) and progress strobes that arrive after completion are also driven, to exercise clamping and the ignore path.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned OPC_W    = 16;
  localparam int unsigned LEN_W    = 21;
  localparam int unsigned RC_W     = 16;
  localparam int unsigned PCT_W    = 7;
  localparam int unsigned PCT_IN_W = 8;
  localparam int unsigned VEND_W   = 16;
  localparam int unsigned DATA_W   = 64;

  localparam logic [RC_W-1:0]  RC_SUCCESS = 16'h0000;
  localparam logic [RC_W-1:0]  RC_BG_RUN  = 16'h0001;
  localparam logic [RC_W-1:0]  RC_BUSY    = 16'h0002;
  localparam logic [PCT_W-1:0] PCT_DONE   = 7'd100;

  // word indices (byte address bits 4:3)
  localparam logic [1:0] W_CAPCTL = 2'd0;
  localparam logic [1:0] W_CMD    = 2'd1;
  localparam logic [1:0] W_STAT   = 2'd2;
  localparam logic [1:0] W_BGSTAT = 2'd3;

  typedef enum logic {ST_IDLE, ST_WAIT} fsm_state_e;
endpackage

// File: rtl/mbox_reg_file.sv
module mbox_reg_file
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter bit          IRQ_CAP = 1'b1,
  parameter logic [31:0] CAP_VAL = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              db_clr_i,
  input  logic [DATA_W-1:0] stat_word_i,
  input  logic [DATA_W-1:0] bg_word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              doorbell_o,
  output logic              irq_en_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             wr_ctl, wr_cmd;
  logic             doorbell_q;
  logic [OPC_W-1:0] opc_q;
  logic [LEN_W-1:0] len_q;

  assign idx    = addr_i[ADDR_W-1:3];
  assign wr_ctl = we_i && (idx == IDX_W'(W_CAPCTL));
  assign wr_cmd = we_i && (idx == IDX_W'(W_CMD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      doorbell_q <= 1'b0;
    end else if (db_clr_i) begin
      doorbell_q <= 1'b0;
    end else if (wr_ctl && wdata_i[32]) begin
      doorbell_q <= 1'b1;
    end
  end

  generate
    if (IRQ_CAP) begin : g_irq_en
      logic irq_en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     irq_en_q <= 1'b0;
        else if (wr_ctl) irq_en_q <= wdata_i[34];
      end
      assign irq_en_o = irq_en_q;
    end else begin : g_no_irq_en
      assign irq_en_o = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= '0;
      len_q <= '0;
    end else if (wr_cmd && !doorbell_q) begin
      opc_q <= wdata_i[OPC_W-1:0];
      len_q <= wdata_i[OPC_W+LEN_W-1:OPC_W];
    end
  end

  always_comb begin
    case (idx)
      IDX_W'(W_CAPCTL): rdata_o = {29'b0, irq_en_o, 1'b0, doorbell_q, CAP_VAL};
      IDX_W'(W_CMD):    rdata_o = {{(DATA_W-OPC_W-LEN_W){1'b0}}, len_q, opc_q};
      IDX_W'(W_STAT):   rdata_o = stat_word_i;
      default:          rdata_o = bg_word_i;
    endcase
  end

  assign doorbell_o = doorbell_q;
  assign opcode_o   = opc_q;
  assign len_o      = len_q;

  // R3: command word frozen while doorbell is set
  a_r3_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doorbell_q |=> $stable({opc_q, len_q}));
endmodule

// File: rtl/mbox_cmd_fsm.sv
module mbox_cmd_fsm
  import mbox_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            doorbell_i,
  input  logic            bg_active_i,
  input  logic            be_done_i,
  input  logic            be_bg_i,
  input  logic [RC_W-1:0] be_rc_i,
  output logic            be_start_o,
  output logic            db_clr_o,
  output logic            bg_launch_o,
  output logic [RC_W-1:0] rc_o
);
  fsm_state_e state_q, state_d;
  logic [RC_W-1:0] rc_q, rc_d;

  always_comb begin
    state_d     = state_q;
    rc_d        = rc_q;
    be_start_o  = 1'b0;
    db_clr_o    = 1'b0;
    bg_launch_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (doorbell_i) begin
          if (bg_active_i) begin
            rc_d     = RC_BUSY;
            db_clr_o = 1'b1;
          end else begin
            be_start_o = 1'b1;
            state_d    = ST_WAIT;
          end
        end
      end
      default: begin
        if (be_done_i) begin
          db_clr_o    = 1'b1;
          bg_launch_o = be_bg_i;
          rc_d        = be_bg_i ? RC_BG_RUN : be_rc_i;
          state_d     = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rc_q    <= RC_SUCCESS;
    end else begin
      state_q <= state_d;
      rc_q    <= rc_d;
    end
  end

  assign rc_o = rc_q;

  // R4: issue is a single-cycle pulse
  a_r4_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_start_o |=> !be_start_o);
  // R4: doorbell stays set until the back end answers
  a_r4_db_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !be_done_i) |=> doorbell_i);
  // R9: nothing issued while a background operation runs
  a_r9_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_active_i |-> !be_start_o);
endmodule

// File: rtl/mbox_bg_track.sv
module mbox_bg_track
  import mbox_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic                pct_valid_i,
  input  logic [PCT_IN_W-1:0] pct_i,
  input  logic [RC_W-1:0]     final_rc_i,
  input  logic [VEND_W-1:0]   vendor_i,
  input  logic                irq_en_i,
  output logic                active_o,
  output logic [DATA_W-1:0]   bg_word_o,
  output logic                irq_o
);
  localparam int unsigned GAP_W = 32 - OPC_W - PCT_W;

  logic              active_q;
  logic [OPC_W-1:0]  opc_q;
  logic [PCT_W-1:0]  pct_q, pct_clamp;
  logic [RC_W-1:0]   rc_q;
  logic [VEND_W-1:0] vend_q;
  logic              upd, finish, irq_q;

  assign pct_clamp = (pct_i > PCT_IN_W'(PCT_DONE)) ? PCT_DONE : pct_i[PCT_W-1:0];
  assign upd       = active_q && pct_valid_i;
  assign finish    = upd && (pct_clamp == PCT_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      opc_q    <= '0;
      pct_q    <= '0;
      rc_q     <= '0;
      vend_q   <= '0;
    end else if (launch_i) begin
      active_q <= 1'b1;
      opc_q    <= opcode_i;
      pct_q    <= '0;
      rc_q     <= '0;
      vend_q   <= '0;
    end else if (upd) begin
      pct_q <= pct_clamp;
      if (finish) begin
        active_q <= 1'b0;
        rc_q     <= final_rc_i;
        vend_q   <= vendor_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= finish && irq_en_i;
  end

  assign active_o  = active_q;
  assign irq_o     = irq_q;
  assign bg_word_o = {vend_q, rc_q, {GAP_W{1'b0}}, pct_q, opc_q};

  // R7: percent never exceeds 100
  a_r7_pct_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pct_q <= PCT_DONE);
  // R8: deferred codes stay zero while running
  a_r8_rc_zero_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (rc_q == '0 && vend_q == '0));
  // R10: interrupt is a single pulse, only after completion
  a_r10_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  a_r10_irq_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (!active_q && pct_q == PCT_DONE));
endmodule

// File: rtl/mbox_bg_ctrl.sv
module mbox_bg_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned PAYLOAD_EXP = 11,
  parameter bit          IRQ_CAP     = 1'b1,
  parameter int unsigned IRQ_MSGNUM  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [4:0]    reg_addr_i,
  input  logic [63:0]   reg_wdata_i,
  output logic [63:0]   reg_rdata_o,
  output logic          be_start_o,
  output logic [15:0]   be_opcode_o,
  output logic [20:0]   be_len_o,
  input  logic          be_done_i,
  input  logic          be_bg_i,
  input  logic [15:0]   be_rc_i,
  input  logic          be_pct_valid_i,
  input  logic [7:0]    be_pct_i,
  input  logic [15:0]   be_final_rc_i,
  input  logic [15:0]   be_vendor_i,
  output logic          irq_o
);
  localparam logic [31:0] CAP_VAL = {21'b0, 4'(IRQ_MSGNUM), IRQ_CAP, 1'b0, 5'(PAYLOAD_EXP)};

  logic              doorbell, irq_en, db_clr, bg_launch, bg_active;
  logic [RC_W-1:0]   rc;
  logic [DATA_W-1:0] stat_word, bg_word;

  assign stat_word = {16'b0, rc, 31'b0, bg_active};

  mbox_reg_file #(
    .ADDR_W (ADDR_W),
    .IRQ_CAP(IRQ_CAP),
    .CAP_VAL(CAP_VAL)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i[ADDR_W-1:0]),
    .wdata_i    (reg_wdata_i),
    .db_clr_i   (db_clr),
    .stat_word_i(stat_word),
    .bg_word_i  (bg_word),
    .rdata_o    (reg_rdata_o),
    .doorbell_o (doorbell),
    .irq_en_o   (irq_en),
    .opcode_o   (be_opcode_o),
    .len_o      (be_len_o)
  );

  mbox_cmd_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .doorbell_i (doorbell),
    .bg_active_i(bg_active),
    .be_done_i  (be_done_i),
    .be_bg_i    (be_bg_i),
    .be_rc_i    (be_rc_i),
    .be_start_o (be_start_o),
    .db_clr_o   (db_clr),
    .bg_launch_o(bg_launch),
    .rc_o       (rc)
  );

  mbox_bg_track u_bg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (bg_launch),
    .opcode_i   (be_opcode_o),
    .pct_valid_i(be_pct_valid_i),
    .pct_i      (be_pct_i),
    .final_rc_i (be_final_rc_i),
    .vendor_i   (be_vendor_i),
    .irq_en_i   (irq_en),
    .active_o   (bg_active),
    .bg_word_o  (bg_word),
    .irq_o      (irq_o)
  );

  // R6: a launch always starts from zero percent
  a_r6_launch_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bg_active) |-> (bg_word[22:16] == 7'd0 && rc == RC_BG_RUN));
endmodule

// File: tb/sim_mbox_bg_ctrl.sv
`timescale 1ns/1ps
module sim_mbox_bg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic        start;
  logic [15:0] b_opc;
  logic [20:0] b_len;
  logic        done = 1'b0, bg = 1'b0, pv = 1'b0;
  logic [15:0] rc = '0, frc = '0, vend = '0;
  logic [7:0]  pct = '0;
  logic        irq;

  int checks = 0, errors = 0, irq_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mbox_bg_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .be_start_o(start),
    .be_opcode_o(b_opc), .be_len_o(b_len), .be_done_i(done), .be_bg_i(bg),
    .be_rc_i(rc), .be_pct_valid_i(pv), .be_pct_i(pct),
    .be_final_rc_i(frc), .be_vendor_i(vend), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  typedef struct packed {
    logic [15:0] opc;
    logic [20:0] len;
    logic        bgf;
    logic [15:0] irc;
    logic [15:0] frc;
    logic [7:0]  last;
    logic        ien;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h0100, 21'd8,        1'b0, 16'h0000, 16'h0000, 8'd0,   1'b0},
    '{16'h4400, 21'h40,       1'b1, 16'h0000, 16'h0000, 8'd100, 1'b1},
    '{16'h0301, 21'd0,        1'b0, 16'h0015, 16'h0000, 8'd0,   1'b1},
    '{16'h4401, 21'h1FFFFF,   1'b1, 16'h0000, 16'h0007, 8'd200, 1'b0},
    '{16'hABCD, 21'd3,        1'b1, 16'h0000, 16'h0005, 8'd100, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [63:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic answer(input logic b, input logic [15:0] r);
    @(negedge clk);
    done = 1'b1; bg = b; rc = r;
    @(negedge clk);
    done = 1'b0; bg = 1'b0; rc = '0;
  endtask

  task automatic progress(input logic [7:0] p, input logic [15:0] f, input logic [15:0] v);
    @(negedge clk);
    pv = 1'b1; pct = p; frc = f; vend = v;
    @(negedge clk);
    pv = 1'b0; pct = '0; frc = '0; vend = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, d); chk("R1 cap", d[31:0], 64'h2CB); chk("R1 ctrl", d[63:32], 64'h0);
    rd(5'h08, d); chk("R1 cmd", d, 64'h0);
    rd(5'h10, d); chk("R1 status", d, 64'h0);
    rd(5'h18, d); chk("R1 bgstat", d, 64'h0);

    // R2 read-only words
    wr(5'h00, 64'h0000_0000_FFFF_FFFE);
    wr(5'h10, '1);
    wr(5'h18, '1);
    rd(5'h00, d); chk("R2 cap", d, 64'h2CB);
    rd(5'h10, d); chk("R2 status", d, 64'h0);
    rd(5'h18, d); chk("R2 bgstat", d, 64'h0);

    for (int i = 0; i < 5; i++) begin
      vec_t v;
      v = VECS[i];
      wr(5'h08, {27'b0, v.len, v.opc});
      rd(5'h08, d); chk("R3 cmd fields", d, {27'b0, v.len, v.opc});
      wr(5'h00, {29'b0, v.ien, 1'b0, 1'b1, 32'b0});
      #1;
      chk("R4 start", {47'b0, start, b_opc}, {47'b0, 1'b1, v.opc});
      chk("R4 len", {43'b0, b_len}, {43'b0, v.len});
      rd(5'h00, d); chk("R11 ien", {63'b0, d[34]}, {63'b0, v.ien});
      @(negedge clk); #1;
      chk("R4 pulse", {63'b0, start}, 64'h0);
      rd(5'h00, d); chk("R4 db held", {63'b0, d[32]}, 64'h1);
      answer(v.bgf, v.irc);
      rd(5'h00, d); chk("R4 db clear", {63'b0, d[32]}, 64'h0);
      rd(5'h10, d);
      if (!v.bgf) begin
        chk("R5 imm", d, {16'b0, v.irc, 32'b0});
      end else begin
        chk("R6 bg start", d, {16'b0, 16'h0001, 32'h1});
        rd(5'h18, d); chk("R6 bgstat", d, {48'b0, v.opc});
        progress(8'd40, 16'hFFFF, 16'hFFFF);
        rd(5'h18, d); chk("R7 pct", d, {32'b0, 9'b0, 7'd40, v.opc});
        rd(5'h10, d); chk("R8 still active", {63'b0, d[0]}, 64'h1);
        i0 = irq_cnt;
        progress(v.last, v.frc, v.frc ^ 16'h5A5A);
        @(negedge clk); #1;
        chk("R10 irq count", 64'(irq_cnt - i0), 64'(v.ien));
        rd(5'h18, d);
        chk("R8 done word", d, {v.frc ^ 16'h5A5A, v.frc, 9'b0, 7'd100, v.opc});
        rd(5'h10, d); chk("R8 inactive", {63'b0, d[0]}, 64'h0);
      end
    end

    // R7 progress ignored when idle
    progress(8'd50, 16'h1111, 16'h2222);
    rd(5'h18, d); chk("R7 idle ignore", d[31:16], 64'(7'd100));
    chk("R7 idle rc", d[63:32], {16'h5A5F, 16'h0005});

    // R9 busy doorbell, R3 cmd lock, R10 enable withdrawn
    wr(5'h08, {27'b0, 21'd9, 16'h7777});
    wr(5'h00, {29'b0, 1'b1, 1'b0, 1'b1, 32'b0});
    wr(5'h08, {27'b0, 21'd1, 16'h1234});
    rd(5'h08, d); chk("R3 cmd locked", d, {27'b0, 21'd9, 16'h7777});
    answer(1'b1, 16'h0);
    progress(8'd30, 16'h0, 16'h0);
    wr(5'h08, {27'b0, 21'd2, 16'h8888});
    wr(5'h00, {29'b0, 1'b1, 1'b0, 1'b1, 32'b0});
    #1 chk("R9 no start", {63'b0, start}, 64'h0);
    @(negedge clk); #1;
    chk("R9 no start later", {63'b0, start}, 64'h0);
    rd(5'h10, d); chk("R9 busy rc", d, {16'b0, 16'h0002, 32'h1});
    rd(5'h00, d); chk("R9 db cleared", {63'b0, d[32]}, 64'h0);
    rd(5'h18, d); chk("R9 bg untouched", d, {32'b0, 9'b0, 7'd30, 16'h7777});
    wr(5'h00, 64'h0);
    rd(5'h00, d); chk("R11 ien off", {63'b0, d[34]}, 64'h0);
    i0 = irq_cnt;
    progress(8'd100, 16'h0009, 16'h0003);
    repeat (2) @(negedge clk);
    #1 chk("R10 no irq disabled", 64'(irq_cnt - i0), 64'h0);
    rd(5'h18, d); chk("R8 final", d[63:32], {16'h0003, 16'h0009});

    // R4 writing 0 does not clear doorbell
    wr(5'h00, {31'b0, 1'b1, 32'b0});
    wr(5'h00, 64'h0);
    rd(5'h00, d); chk("R4 db sticky", {63'b0, d[32]}, 64'h1);
    answer(1'b0, 16'h0000);
    rd(5'h10, d); chk("R5 success", d, 64'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule